// File: doc/BRIEF.md
# I2C Target Controller with Receive Clock Stretching

This block is the target (slave) side of an I2C-compatible two-wire bus. It answers to a 7-bit address set by the host. In write direction it collects each data byte in a shift register and moves it into a one-byte receive holding register, where the host picks it up with a read strobe. In read direction it sends the byte the host has placed in a transmit holding register, most significant bit first. Both bus lines are open-drain: the block only ever pulls a line low, through `scl_oe` and `sda_oe`.

Back-pressure works in one place only. The controller stretches the clock when the holding register still holds an unread byte and the shifter has just completed another one. It pulls SCL low after the falling edge of that byte's eighth bit and raises `sts_clk_wait` for as long as it holds the line. Status flags report:
- an active addressed access;
- the direction of the access;
- receive data waiting;
- an empty transmit holding register;
- the end of an access.

The transfer-complete flag is held back across a repeated START that addresses this target again. It is raised only when the access really ends.

The state machine has nine states:
- IDLE waits for a START.
- ADDR shifts in the address byte.
- ADDR_ACK acknowledges a matching address.
- RX_BYTE shifts in a write byte.
- RX_STALL holds SCL low until the holding register is free.
- RX_ACK acknowledges a received byte.
- TX_BYTE drives a read byte.
- TX_ACK samples the master's acknowledge.
- IGNORE keeps both lines released.

The transitions are:
- A START from any state goes to ADDR, and a STOP from any state goes to IDLE.
- ADDR goes to ADDR_ACK on a match and to IGNORE otherwise.
- ADDR_ACK goes to TX_BYTE or RX_BYTE according to the direction bit.
- RX_BYTE goes to RX_ACK if the holding register is empty and to RX_STALL if it is full.
- RX_STALL goes to RX_ACK once the host has read the holding register.
- RX_ACK goes back to RX_BYTE.
- TX_BYTE goes to TX_ACK after eight bits.
- TX_ACK goes to TX_BYTE on an ACK and to IGNORE on a NACK.

Top module: `i2c_tgt_ctrl`

## Requirements
- R1: The address byte following a START is compared as bits [7:1] against `cfg_addr`. On a match the block pulls SDA low during the ninth clock (ACK). Otherwise it leaves SDA released (NACK) and sets no flags.
- R2: Each write data byte appears on `rx_data` with `sts_rx_ready` set, in bus order. Address bytes and bytes sent to another address never load the holding register. `host_rd_rx` clears `sts_rx_ready`, and nothing else clears it.
- R3: If the holding register is full when a write byte's eighth bit ends, SCL is held low until the host reads the holding register. `sts_clk_wait` is high exactly while SCL is held. No stretching occurs while the holding register is empty.
- R4: In read direction the transmit holding byte is sent MSB first, with each bit driven while SCL is low. `sts_tx_ready` falls after a `host_wr_tx` strobe and rises again when the byte is loaded into the shifter.
- R5: After a NACK from the master in read direction, SDA stays released until the next START or STOP.
- R6: `sts_access` sets on a matching address. `sts_read` equals the R/W bit of the latest matching address, where 1 means read.
- R7: `sts_xfer_done` clears on a matching address. It sets on a STOP ending an access, or on a repeated START with a non-matching address. It stays clear across a repeated START that re-addresses this target.
- R8: `sts_end_access` pulses high for exactly one cycle when an access ends through a STOP or a non-matching repeated START, and not otherwise.
- R9: After reset both lines are released, `sts_rx_ready`, `sts_access` and `sts_clk_wait` are 0, and `sts_tx_ready` and `sts_xfer_done` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_addr | input | 7 | Target address |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| host_rd_rx | input | 1 | Host read strobe for the receive holding register |
| rx_data | output | 8 | Receive holding register |
| host_wr_tx | input | 1 | Host write strobe for the transmit holding register |
| tx_wdata | input | 8 | Byte written to the transmit holding register |
| sts_access | output | 1 | Addressed access in progress |
| sts_read | output | 1 | Direction of the latest matching address (1 = read) |
| sts_rx_ready | output | 1 | Receive holding register holds an unread byte |
| sts_tx_ready | output | 1 | Transmit holding register is empty |
| sts_clk_wait | output | 1 | SCL is being stretched |
| sts_end_access | output | 1 | One-cycle pulse at the end of an access |
| sts_xfer_done | output | 1 | Transfer complete |

## Verification
The bench withholds host reads so that a second write byte lands while the holding register is full. A design that stretches at the wrong moment would either overwrite the first byte, which shows as a scoreboard miscompare, or never release SCL, which hangs the bus. It runs a read access followed by a repeated START that re-addresses the target for writing. A design that raises transfer-complete or pulses end-of-access at the restart is caught there. It also sends a non-matching restart, a foreign address carrying data, and a read byte issued after the master's NACK. These catch a wrong acknowledge, a leaked byte, and SDA still being driven after the NACK.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_RX_BYTE,
        ST_RX_STALL,
        ST_RX_ACK,
        ST_TX_BYTE,
        ST_TX_ACK,
        ST_IGNORE
    } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_linesync.sv
module i2c_tgt_linesync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe, sda_pipe;
    logic scl_q, sda_q, scl_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    // SDA edge while SCL stays high
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_tgt_rxbuf.sv
module i2c_tgt_rxbuf #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         rd,
    output logic [W-1:0] data,
    output logic         ready
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data  <= '0;
            ready <= 1'b0;
        end else if (load) begin
            data  <= load_data;
            ready <= 1'b1;
        end else if (rd) begin
            ready <= 1'b0;
        end
    end
endmodule

// File: rtl/i2c_tgt_txbuf.sv
module i2c_tgt_txbuf #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         take,
    output logic [W-1:0] data,
    output logic         empty
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data  <= '0;
            empty <= 1'b1;
        end else if (wr) begin
            data  <= wdata;
            empty <= 1'b0;
        end else if (take) begin
            empty <= 1'b1;
        end
    end
endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
    import i2c_tgt_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-2:0] cfg_addr,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic              host_rd_rx,
    output logic [DATA_W-1:0] rx_data,
    input  logic              host_wr_tx,
    input  logic [DATA_W-1:0] tx_wdata,
    output logic              sts_access,
    output logic              sts_read,
    output logic              sts_rx_ready,
    output logic              sts_tx_ready,
    output logic              sts_clk_wait,
    output logic              sts_end_access,
    output logic              sts_xfer_done
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

    tgt_state_e        state;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] shreg, txsh, tx_hold;
    logic              ack_ok, access, rd_dir, xfer_done, end_pulse;
    logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              bus_evt, rx_load, tx_take;

    i2c_tgt_linesync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    assign bus_evt = start_det | stop_det;
    // byte enters holding register straight from shifter, or after a stall
    assign rx_load = !bus_evt && !sts_rx_ready &&
                     ((state == ST_RX_BYTE && scl_fall && cnt == CNT_FULL) ||
                      (state == ST_RX_STALL));
    assign tx_take = !bus_evt && scl_fall &&
                     ((state == ST_ADDR_ACK && rd_dir) ||
                      (state == ST_TX_ACK && ack_ok));

    i2c_tgt_rxbuf #(.W(DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .load(rx_load), .load_data(shreg),
        .rd(host_rd_rx), .data(rx_data), .ready(sts_rx_ready)
    );

    i2c_tgt_txbuf #(.W(DATA_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .wr(host_wr_tx), .wdata(tx_wdata),
        .take(tx_take), .data(tx_hold), .empty(sts_tx_ready)
    );

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            shreg     <= '0;
            txsh      <= '0;
            ack_ok    <= 1'b0;
            access    <= 1'b0;
            rd_dir    <= 1'b0;
            xfer_done <= 1'b1;
            end_pulse <= 1'b0;
        end else begin
            end_pulse <= 1'b0;
            if (stop_det) begin
                state <= ST_IDLE;
                if (access) begin
                    access    <= 1'b0;
                    xfer_done <= 1'b1;
                    end_pulse <= 1'b1;
                end
            end else if (start_det) begin
                state <= ST_ADDR;
                cnt   <= '0;
            end else begin
                unique case (state)
                    ST_IDLE: ;
                    ST_ADDR: begin
                        if (scl_rise) begin
                            shreg <= {shreg[DATA_W-2:0], sda_s};
                            cnt   <= cnt + 1'b1;
                        end else if (scl_fall && cnt == CNT_FULL) begin
                            if (shreg[DATA_W-1:1] == cfg_addr) begin
                                state     <= ST_ADDR_ACK;
                                access    <= 1'b1;
                                rd_dir    <= shreg[0];
                                xfer_done <= 1'b0;
                            end else begin
                                state <= ST_IGNORE;
                                if (access) begin
                                    access    <= 1'b0;
                                    xfer_done <= 1'b1;
                                    end_pulse <= 1'b1;
                                end
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            cnt <= '0;
                            if (rd_dir) begin
                                state <= ST_TX_BYTE;
                                txsh  <= tx_hold;
                            end else begin
                                state <= ST_RX_BYTE;
                            end
                        end
                    end
                    ST_RX_BYTE: begin
                        if (scl_rise) begin
                            shreg <= {shreg[DATA_W-2:0], sda_s};
                            cnt   <= cnt + 1'b1;
                        end else if (scl_fall && cnt == CNT_FULL) begin
                            state <= sts_rx_ready ? ST_RX_STALL : ST_RX_ACK;
                        end
                    end
                    ST_RX_STALL: begin
                        if (!sts_rx_ready) state <= ST_RX_ACK;
                    end
                    ST_RX_ACK: begin
                        if (scl_fall) begin
                            state <= ST_RX_BYTE;
                            cnt   <= '0;
                        end
                    end
                    ST_TX_BYTE: begin
                        if (scl_fall) begin
                            if (cnt == CNT_LAST) begin
                                state <= ST_TX_ACK;
                            end else begin
                                txsh <= {txsh[DATA_W-2:0], 1'b1};
                                cnt  <= cnt + 1'b1;
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (scl_rise) begin
                            ack_ok <= ~sda_s;
                        end else if (scl_fall) begin
                            if (ack_ok) begin
                                state <= ST_TX_BYTE;
                                txsh  <= tx_hold;
                                cnt   <= '0;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                    end
                    ST_IGNORE: ;
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        scl_oe = 1'b0;
        sda_oe = 1'b0;
        unique case (state)
            ST_ADDR_ACK: sda_oe = 1'b1;
            ST_RX_STALL: begin
                scl_oe = 1'b1;
                sda_oe = 1'b1;
            end
            ST_RX_ACK:   sda_oe = 1'b1;
            ST_TX_BYTE:  sda_oe = ~txsh[DATA_W-1];
            default: ;
        endcase
    end

    assign sts_clk_wait   = (state == ST_RX_STALL);
    assign sts_access     = access;
    assign sts_read       = rd_dir;
    assign sts_xfer_done  = xfer_done;
    assign sts_end_access = end_pulse;
endmodule

// File: rtl/i2c_tgt_ctrl_chk.sv
module i2c_tgt_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_oe,
    input logic rx_ready,
    input logic host_rd_rx,
    input logic tx_ready,
    input logic host_wr_tx,
    input logic end_access,
    input logic xfer_done,
    input logic access
);
    assert_rx_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ready && !host_rd_rx) |=> rx_ready);

    assert_stretch_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_oe && !rx_ready) |=> !scl_oe);

    assert_tx_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_ready) |-> $past(host_wr_tx));

    assert_done_on_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(access) |-> !xfer_done);

    assert_end_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        end_access |=> !end_access);

    assert_end_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        end_access |-> (xfer_done && !access));
endmodule

bind i2c_tgt_ctrl i2c_tgt_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_oe(scl_oe), .rx_ready(sts_rx_ready),
    .host_rd_rx(host_rd_rx), .tx_ready(sts_tx_ready), .host_wr_tx(host_wr_tx),
    .end_access(sts_end_access), .xfer_done(sts_xfer_done), .access(sts_access)
);

// File: tb/i2c_tgt_ctrl_tb_top.sv
module i2c_tgt_ctrl_tb_top;
    localparam int Q = 20;
    localparam logic [6:0] MY_ADDR = 7'h3A;
    localparam logic [6:0] OTHER_ADDR = 7'h15;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic scl_oe, sda_oe, scl_line, sda_line;
    logic host_rd_rx = 1'b0, host_wr_tx = 1'b0;
    logic [7:0] tx_wdata = 8'h00;
    logic [7:0] rx_data;
    logic sts_access, sts_read, sts_rx_ready, sts_tx_ready;
    logic sts_clk_wait, sts_end_access, sts_xfer_done;

    int vectors = 0, miscompares = 0;
    int end_cnt = 0, wait_cnt = 0, rx_reads = 0;
    logic host_hold = 1'b0;
    logic [7:0] exp_q[$];

    always #2.5 clk = ~clk;

    assign scl_line = m_scl & ~scl_oe;
    assign sda_line = m_sda & ~sda_oe;

    i2c_tgt_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_addr(MY_ADDR),
        .scl_i(scl_line), .sda_i(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .host_rd_rx(host_rd_rx), .rx_data(rx_data),
        .host_wr_tx(host_wr_tx), .tx_wdata(tx_wdata),
        .sts_access(sts_access), .sts_read(sts_read),
        .sts_rx_ready(sts_rx_ready), .sts_tx_ready(sts_tx_ready),
        .sts_clk_wait(sts_clk_wait), .sts_end_access(sts_end_access),
        .sts_xfer_done(sts_xfer_done)
    );

    task automatic chk(input string req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    // event counters sampled away from the active edge
    always @(negedge clk) begin
        if (sts_end_access) end_cnt++;
        if (sts_clk_wait) wait_cnt++;
    end

    // monitor: host reads and scoreboard compare (R2)
    always begin
        @(negedge clk);
        host_rd_rx = 1'b0;
        if (rst_n && sts_rx_ready && !host_hold) begin
            rx_reads++;
            if (exp_q.size() == 0) begin
                chk("R2", {24'h0, rx_data}, 32'hFFFF_FFFF, "unexpected rx byte");
            end else begin
                chk("R2", {24'h0, rx_data}, {24'h0, exp_q.pop_front()}, "rx byte");
            end
            host_rd_rx = 1'b1;
        end
    end

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic wait_high();
        while (!scl_line) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; m_scl = 1'b1; wq();
        m_sda = 1'b0; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic bus_restart();
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wait_high(); wq();
        m_sda = 1'b0; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq();
        m_scl = 1'b1; wait_high(); wq();
        m_sda = 1'b1; wq();
    endtask

    task automatic wr_bit(input logic b);
        m_sda = b; wq();
        m_scl = 1'b1; wait_high(); wq(); wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic rd_bit(output logic b);
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wait_high(); wq();
        b = sda_line; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic wr_bits(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) wr_bit(v[i]);
    endtask

    task automatic wr_byte(input logic [7:0] v, output logic ack);
        wr_bits(v);
        rd_bit(ack);
    endtask

    task automatic rd_byte(input logic nack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            rd_bit(b);
            v[i] = b;
        end
        wr_bit(nack);
    endtask

    task automatic host_write(input logic [7:0] v);
        @(negedge clk);
        tx_wdata = v; host_wr_tx = 1'b1;
        @(negedge clk);
        host_wr_tx = 1'b0;
    endtask

    // driver: writes a byte and pushes it as expected receive data
    task automatic send_data(input logic [7:0] v, input string req);
        logic ack;
        exp_q.push_back(v);
        wr_byte(v, ack);
        chk(req, {31'h0, ack}, 32'h0, "data ACK");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] rv;
        int ends0, reads0;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk("R9", {30'h0, scl_oe, sda_oe}, 32'h0, "lines released");
        chk("R9", {27'h0, sts_rx_ready, sts_access, sts_clk_wait, sts_tx_ready, sts_xfer_done},
            32'h3, "reset flags");

        // plain write access, host reads freely
        bus_start();
        wr_byte({MY_ADDR, 1'b0}, ack);
        chk("R1", {31'h0, ack}, 32'h0, "address ACK");
        chk("R6", {30'h0, sts_access, sts_read}, 32'h2, "access/write dir");
        chk("R7", {31'h0, sts_xfer_done}, 32'h0, "done cleared on match");
        send_data(8'h11, "R2");
        send_data(8'h22, "R2");
        send_data(8'h35, "R2");
        ends0 = end_cnt;
        bus_stop();
        chk("R8", end_cnt - ends0, 1, "end pulse on stop");
        chk("R7", {30'h0, sts_xfer_done, sts_access}, 32'h2, "done after stop");
        chk("R3", wait_cnt, 0, "no stretch with empty holding reg");
        chk("R2", exp_q.size(), 0, "all bytes delivered");

        // foreign address: NACK, data ignored
        reads0 = rx_reads;
        ends0 = end_cnt;
        bus_start();
        wr_byte({OTHER_ADDR, 1'b0}, ack);
        chk("R1", {31'h0, ack}, 32'h1, "foreign address NACK");
        chk("R1", {31'h0, sts_access}, 32'h0, "no access on foreign");
        wr_byte(8'h77, ack);
        chk("R2", {31'h0, sts_rx_ready}, 32'h0, "foreign data not loaded");
        bus_stop();
        chk("R2", rx_reads - reads0, 0, "no host reads for foreign data");
        chk("R8", end_cnt - ends0, 0, "no end pulse for foreign");
        chk("R7", {31'h0, sts_xfer_done}, 32'h1, "done unchanged");

        // stretching with the holding register full
        host_hold = 1'b1;
        bus_start();
        wr_byte({MY_ADDR, 1'b0}, ack);
        send_data(8'hA1, "R2");
        exp_q.push_back(8'hB2);
        wr_bits(8'hB2);
        fork
            rd_bit(ack);
            begin
                repeat (60) @(negedge clk);
                chk("R3", {30'h0, sts_clk_wait, scl_line}, 32'h2, "stretch active");
                chk("R3", {31'h0, sts_rx_ready}, 32'h1, "holding full in stretch");
                host_hold = 1'b0;
            end
        join
        chk("R3", {31'h0, ack}, 32'h0, "ACK after stretch");
        chk("R3", {31'h0, sts_clk_wait}, 32'h0, "clock wait released");
        chk("R3", (wait_cnt > 0) ? 1 : 0, 1, "stretch observed");
        bus_stop();
        chk("R2", exp_q.size(), 0, "stalled byte delivered in order");

        // read access with NACK
        host_write(8'hC5);
        chk("R4", {31'h0, sts_tx_ready}, 32'h0, "tx holding filled");
        bus_start();
        wr_byte({MY_ADDR, 1'b1}, ack);
        chk("R6", {30'h0, sts_access, sts_read}, 32'h3, "read dir");
        chk("R4", {31'h0, sts_tx_ready}, 32'h1, "tx byte taken");
        host_write(8'h3C);
        rd_byte(1'b0, rv);
        chk("R4", {24'h0, rv}, 32'hC5, "first read byte");
        rd_byte(1'b1, rv);
        chk("R4", {24'h0, rv}, 32'h3C, "second read byte");
        rd_byte(1'b1, rv);
        chk("R5", {24'h0, rv}, 32'hFF, "SDA released after NACK");
        bus_stop();

        // read then repeated START writing to same target
        host_write(8'h5E);
        bus_start();
        wr_byte({MY_ADDR, 1'b1}, ack);
        rd_byte(1'b1, rv);
        chk("R4", {24'h0, rv}, 32'h5E, "read before reversal");
        ends0 = end_cnt;
        bus_restart();
        wr_byte({MY_ADDR, 1'b0}, ack);
        chk("R7", {31'h0, sts_xfer_done}, 32'h0, "done held over same restart");
        chk("R8", end_cnt - ends0, 0, "no end pulse on same restart");
        chk("R6", {30'h0, sts_access, sts_read}, 32'h2, "direction reversed");
        send_data(8'h99, "R2");
        bus_stop();
        chk("R7", {31'h0, sts_xfer_done}, 32'h1, "done at final stop");
        chk("R8", end_cnt - ends0, 1, "single end pulse");

        // write then restart to another address
        bus_start();
        wr_byte({MY_ADDR, 1'b0}, ack);
        send_data(8'h42, "R2");
        ends0 = end_cnt;
        bus_restart();
        wr_byte({OTHER_ADDR, 1'b0}, ack);
        chk("R1", {31'h0, ack}, 32'h1, "restart foreign NACK");
        chk("R7", {30'h0, sts_xfer_done, sts_access}, 32'h2, "done on foreign restart");
        chk("R8", end_cnt - ends0, 1, "end pulse on foreign restart");
        bus_stop();
        chk("R8", end_cnt - ends0, 1, "no extra pulse at stop");
        chk("R2", exp_q.size(), 0, "scoreboard drained");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule